// File: doc/BRIEF.md
# Sprite Attribute Block Copier

This block moves a fixed run of 160 bytes from a software-chosen source area into the sprite attribute RAM, one byte per step, with no CPU involvement after the trigger. A single-cycle start strobe carries a 16-bit base address. When the base is acceptable, the engine loads its source pointer with it, clears its sprite-RAM index and counts the 160 bytes down to zero. Time is measured in machine cycles, delivered as a clock-enable strobe (`tick`). The first byte moves on the 8th tick after the start. Each later byte follows 4 ticks after the one before.

The source side is a plain read port. The engine drives `src_addr` from a register and samples `src_data` in the cycle a step fires, so the memory behind it must answer in the same cycle. The destination side is a registered write port (`spr_we`, `spr_idx`, `spr_wdata`). `busy` is high for the whole transfer so that the surrounding address decoder can fence off conflicting CPU accesses. `done` pulses once when the last byte has been written.

A start whose base lies above 0xF100 is dropped and changes nothing. An acceptable start that arrives mid-transfer discards the pending step and begins again from the new base, with the full 8-tick lead.

Top module: `spr_dma_engine`

## Requirements
- R1: A start with `start_base` greater than 0xF100 is ignored. An idle engine stays idle and `src_addr` keeps its value; a running transfer continues unchanged. A base of exactly 0xF100 is accepted.
- R2: On the cycle after an accepted start, `busy` is 1 and `src_addr` equals the base. The transfer then writes 160 bytes to indices 0 through 159.
- R3: The first write fires on the edge that samples the 8th `tick` after the start edge. A tick that is high on the start edge itself does not count. `spr_we` is high in the cycle that follows the firing edge.
- R4: Each later write fires on the edge that samples the 4th `tick` after the previous firing edge. Without ticks, no write is issued.
- R5: Write number k (counting from 0) carries `spr_idx` = k and `spr_wdata` = the `src_data` value presented while `src_addr` = base + k.
- R6: In the cycle where `spr_we` shows index 159, `busy` is 0 and `done` is 1. `done` is high for that one cycle only, and no further writes follow.
- R7: An accepted start during a transfer cancels the pending step, even one that would fire on that same edge. The transfer restarts at index 0 from the new base, with an 8-tick lead.
- R8: While `rst` is high, and in the cycle after it, `busy`, `done` and `spr_we` are 0 and `src_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable strobe; the unit of all transfer delays |
| start | input | 1 | One-cycle start request |
| start_base | input | 16 | Source base address carried with `start` |
| src_addr | output | 16 | Current source read address |
| src_data | input | 8 | Source byte at `src_addr`, valid in the same cycle |
| spr_we | output | 1 | Sprite RAM write strobe |
| spr_idx | output | 8 | Sprite RAM byte index |
| spr_wdata | output | 8 | Sprite RAM write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
The hardest case to reach from the ports is a restart whose start edge is also the edge where the old transfer's next byte would have fired. That collision needs the tick count to sit exactly one short of a step when the new start arrives. The bench reaches it with a run that stops after a chosen number of ticks (7, then 87), and then issues the new start with `tick` held high on the same edge. Every write after that must carry the new base's data from index 0, and must keep the 8-tick lead. The bench also issues a rejected start partway through a transfer, with a tick on the same edge, and checks that the sequence continues without a gap.

// File: rtl/spr_dma_pkg.sv
`timescale 1ns/1ps
package spr_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_STREAM = 2'd2
  } dma_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spr_dma_start_gate.sv
`timescale 1ns/1ps
module spr_dma_start_gate #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BASE_LIMIT = 32'hF100
) (
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  output logic              accept
);
  localparam logic [63:0] ADDR_MAX   = (64'd1 << ADDR_W) - 64'd1;
  localparam bit          FULL_RANGE = (64'(BASE_LIMIT) >= ADDR_MAX);

  generate
    if (FULL_RANGE) begin : g_open
      assign accept = start;
    end else begin : g_limited
      assign accept = start && (64'(start_base) <= 64'(BASE_LIMIT));
    end
  endgenerate
endmodule

// File: rtl/spr_dma_pacer.sv
`timescale 1ns/1ps
module spr_dma_pacer
  import spr_dma_pkg::*;
#(
  parameter int unsigned FIRST_GAP = 8,
  parameter int unsigned STEP_GAP  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  input  logic active,
  output logic fire
);
  localparam int unsigned GAP_W = $clog2(max_u(FIRST_GAP, STEP_GAP) + 1);

  logic [GAP_W-1:0] gap_q;
  logic             expiring;

  assign expiring = (gap_q == GAP_W'(1));
  assign fire     = active && tick && expiring && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (load) begin
      gap_q <= GAP_W'(FIRST_GAP);
    end else if (active && tick) begin
      if (expiring) gap_q <= GAP_W'(STEP_GAP);
      else          gap_q <= gap_q - GAP_W'(1);
    end
  end
endmodule

// File: rtl/spr_dma_ctrl.sv
`timescale 1ns/1ps
module spr_dma_ctrl
  import spr_dma_pkg::*;
#(
  parameter int unsigned XFER_LEN = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic fire,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(XFER_LEN + 1);

  dma_state_e       state_q;
  logic [CNT_W-1:0] remaining_q;
  logic             done_q;
  logic             final_step;

  assign final_step = (remaining_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      remaining_q <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        state_q     <= ST_LEAD;
        remaining_q <= CNT_W'(XFER_LEN);
      end else if (fire) begin
        remaining_q <= remaining_q - CNT_W'(1);
        if (final_step) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          state_q <= ST_STREAM;
        end
      end
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
endmodule

// File: rtl/spr_dma_datapath.sv
`timescale 1ns/1ps
module spr_dma_datapath #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              fire,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] src_addr,
  output logic              spr_we,
  output logic [IDX_W-1:0]  spr_idx,
  output logic [DATA_W-1:0] spr_wdata
);
  logic [ADDR_W-1:0] ptr_q;
  logic [IDX_W-1:0]  dst_q;
  logic              we_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      dst_q <= '0;
    end else if (load) begin
      ptr_q <= start_base;
      dst_q <= '0;
    end else if (fire) begin
      ptr_q <= ptr_q + ADDR_W'(1);
      dst_q <= dst_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      idx_q   <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= fire;
      if (fire) begin
        idx_q   <= dst_q;
        wdata_q <= src_data;
      end
    end
  end

  assign src_addr  = ptr_q;
  assign spr_we    = we_q;
  assign spr_idx   = idx_q;
  assign spr_wdata = wdata_q;
endmodule

// File: rtl/spr_dma_engine.sv
`timescale 1ns/1ps
module spr_dma_engine #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned XFER_LEN   = 160,
  parameter int unsigned FIRST_GAP  = 8,
  parameter int unsigned STEP_GAP   = 4,
  parameter int unsigned BASE_LIMIT = 32'hF100
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           start_base,
  output logic [ADDR_W-1:0]           src_addr,
  input  logic [DATA_W-1:0]           src_data,
  output logic                        spr_we,
  output logic [$clog2(XFER_LEN)-1:0] spr_idx,
  output logic [DATA_W-1:0]           spr_wdata,
  output logic                        busy,
  output logic                        done
);
  localparam int unsigned IDX_W = $clog2(XFER_LEN);

  logic load;
  logic fire;

  spr_dma_start_gate #(.ADDR_W(ADDR_W), .BASE_LIMIT(BASE_LIMIT)) u_gate (
    .start      (start),
    .start_base (start_base),
    .accept     (load)
  );

  spr_dma_pacer #(.FIRST_GAP(FIRST_GAP), .STEP_GAP(STEP_GAP)) u_pacer (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .tick   (tick),
    .active (busy),
    .fire   (fire)
  );

  spr_dma_ctrl #(.XFER_LEN(XFER_LEN)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .fire (fire),
    .busy (busy),
    .done (done)
  );

  spr_dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .fire       (fire),
    .start_base (start_base),
    .src_data   (src_data),
    .src_addr   (src_addr),
    .spr_we     (spr_we),
    .spr_idx    (spr_idx),
    .spr_wdata  (spr_wdata)
  );
endmodule

// File: rtl/spr_dma_checker.sv
`timescale 1ns/1ps
module spr_dma_checker #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned FIRST_GAP  = 8,
  parameter int unsigned STEP_GAP   = 4,
  parameter int unsigned BASE_LIMIT = 32'hF100
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              start,
  input logic [ADDR_W-1:0] start_base,
  input logic [ADDR_W-1:0] src_addr,
  input logic              spr_we,
  input logic [IDX_W-1:0]  spr_idx,
  input logic              busy,
  input logic              done
);
  logic              base_ok;
  logic [15:0]       ticks_seen;
  logic              lead_phase;
  logic [IDX_W-1:0]  next_idx;

  assign base_ok = start && (64'(start_base) <= 64'(BASE_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks_seen <= '0;
      lead_phase <= 1'b1;
      next_idx   <= '0;
    end else if (base_ok) begin
      ticks_seen <= '0;
      lead_phase <= 1'b1;
      next_idx   <= '0;
    end else if (spr_we) begin
      ticks_seen <= (tick && busy) ? 16'd1 : 16'd0;
      lead_phase <= 1'b0;
      next_idx   <= next_idx + IDX_W'(1);
    end else if (tick && busy && ticks_seen != 16'hFFFF) begin
      ticks_seen <= ticks_seen + 16'd1;
    end
  end

  AST_HIGH_BASE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !base_ok) |=> (!busy && $stable(src_addr))); // R1

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    base_ok |=> (busy && src_addr == $past(start_base))); // R2

  AST_FIRST_LEAD: assert property (@(posedge clk) disable iff (rst)
    (spr_we && lead_phase) |-> (ticks_seen == 16'(FIRST_GAP))); // R3

  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (rst)
    (spr_we && !lead_phase) |-> (ticks_seen == 16'(STEP_GAP))); // R4

  AST_WRITE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    spr_we |-> $past(tick)); // R4

  AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (rst)
    spr_we |-> (spr_idx == next_idx)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_END_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && spr_we)); // R6

  AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (busy && base_ok) |=> (busy && !spr_we && src_addr == $past(start_base))); // R7
endmodule

bind spr_dma_engine spr_dma_checker #(
  .ADDR_W     (ADDR_W),
  .IDX_W      ($clog2(XFER_LEN)),
  .FIRST_GAP  (FIRST_GAP),
  .STEP_GAP   (STEP_GAP),
  .BASE_LIMIT (BASE_LIMIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .start      (start),
  .start_base (start_base),
  .src_addr   (src_addr),
  .spr_we     (spr_we),
  .spr_idx    (spr_idx),
  .busy       (busy),
  .done       (done)
);

// File: tb/sim_spr_dma_engine.sv
`timescale 1ns/1ps
module sim_spr_dma_engine;
  localparam int LEN   = 160;
  localparam int LEAD  = 8;
  localparam int STEP  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_base = '0;
  logic [15:0] src_addr;
  logic [7:0]  src_data;
  logic        spr_we;
  logic [7:0]  spr_idx;
  logic [7:0]  spr_wdata;
  logic        busy;
  logic        done;

  int tests = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  function automatic logic [7:0] src_model(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign src_data = src_model(src_addr);

  spr_dma_engine u0 (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .start_base(start_base),
    .src_addr(src_addr), .src_data(src_data), .spr_we(spr_we), .spr_idx(spr_idx),
    .spr_wdata(spr_wdata), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic next_tick(input int period, input int n);
    if (period == 0) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0] | lfsr[5];
    end
    return (n % period) == 0;
  endfunction

  // Called at a negedge. stop_ticks < 0 runs to completion; inject_at >= 0
  // drives a rejected start after that many writes.
  task automatic go(input logic [15:0] base, input int period, input bit tick_with_start,
                    input int stop_ticks, input int inject_at);
    int  k = 0;
    int  ticks = 0;
    int  n = 0;
    bit  fin = 0;
    bit  injected = 0;
    start = 1'b1; start_base = base; tick = tick_with_start;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", busy, 1);
    check("R2", "src_addr loaded", src_addr, base);
    check("R7", "no write on start edge", spr_we, 0);
    while (!fin) begin
      if (spr_we) begin
        check("R5", "index", spr_idx, k);
        check("R5", "data", spr_wdata, src_model(base + 16'(k)));
        check(k == 0 ? "R3" : "R4", "tick position", ticks, LEAD + STEP * k);
        k++;
        if (k == LEN) begin
          check("R6", "busy at last write", busy, 0);
          check("R6", "done at last write", done, 1);
          fin = 1;
        end else begin
          check("R2", "busy mid transfer", busy, 1);
        end
      end else if (done) begin
        check("R6", "stray done", done, 0);
      end
      if (!fin && stop_ticks >= 0 && ticks == stop_ticks) fin = 1;
      if (!fin) begin
        tick = next_tick(period, n);
        if (tick) ticks++;
        if (!injected && inject_at >= 0 && k == inject_at) begin
          start = 1'b1; start_base = 16'hFFFF; injected = 1;
        end
        @(negedge clk);
        start = 1'b0;
        n++;
        if (n > 20000) begin
          check("R4", "transfer stalled", n, 0);
          fin = 1;
        end
      end
    end
    if (k == LEN) begin
      tick = 1'b1;
      @(negedge clk);
      check("R6", "done one cycle", done, 0);
      check("R6", "no write after end", spr_we, 0);
      check("R6", "idle after end", busy, 0);
      tick = 1'b0;
    end
  endtask

  task automatic idle_reject(input logic [15:0] base);
    logic [15:0] held;
    int          seen = 0;
    held = src_addr;
    start = 1'b1; start_base = base; tick = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (busy || spr_we) seen++;
      @(negedge clk);
    end
    tick = 1'b0;
    check("R1", "rejected base leaves engine idle", seen, 0);
    check("R1", "src_addr unchanged", src_addr, held);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "busy in reset", busy, 0);
    check("R8", "done in reset", done, 0);
    check("R8", "spr_we in reset", spr_we, 0);
    check("R8", "src_addr in reset", src_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8", "busy after reset", busy, 0);

    idle_reject(16'hF101);
    idle_reject(16'hFFFF);
    go(16'hF100, 1, 0, -1, -1);                 // R1 boundary accepted
    idle_reject(16'hF101);                      // R1 after a transfer

    for (int b = 0; b < 16; b++)
      for (int p = 1; p <= 2; p++)
        go(16'(b * 16'h1000 + b * 16'h11), p, (b % 2) == 1, -1, -1);

    go(16'h1234, 3, 1, -1, -1);                 // R3 tick on start edge
    go(16'h5A5A, 0, 0, -1, -1);                 // R4 irregular ticks
    go(16'h8000, 1, 0, -1, 50);                 // R1 reject while busy

    go(16'h2000, 1, 0, LEAD - 1, -1);           // R7 collide with first step
    go(16'hC000, 1, 1, -1, -1);
    go(16'h3000, 1, 0, LEAD + STEP * 20 - 1, -1); // R7 collide mid stream
    go(16'h0700, 1, 1, -1, -1);
    go(16'h4400, 2, 0, 50, -1);                 // R7 restart between steps
    go(16'hE0F0, 2, 0, -1, -1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule